// File: doc/BRIEF.md
# Flash Control Register Bank

This block is the software-visible register bank in front of an on-chip flash array. It holds three byte-wide registers: a control register, a read-only status register and an erase-block select register. It also holds one halfword emulation register. Software reaches them over a simple peripheral bus with a single-cycle request and a single-cycle acknowledge. The block drives the register contents straight to the flash sequencing logic.

Every access is decoded against the register it targets. Each register has its own set of legal sizes. An access is acknowledged only after a fixed number of wait cycles, and that number depends on the register and the size. A mode input tells the bank whether the flash is enabled, and it gates the byte registers. An external write-enable pin is shown live in the control register. Together with a software-enable bit, that pin decides whether the erase-block register may hold a value at all. Illegal accesses still complete with the normal wait time, but they change nothing, return zero and pulse an error flag with the acknowledge.

Top module: `flash_ctl_regs`

## Requirements
- R1: Byte offset 0 selects the control register, offset 1 the status register and offset 2 the erase-block register. Offset 8 selects the emulation register. A control-register read returns {pin level, software-enable bit, 6'b0}. Byte data travels in bits 7:0 of the data buses.
- R2: The three byte registers accept only byte accesses (size code 0). Word (1), longword (2) or invalid (3) sizes on them complete in 3 cycles with read data 0 and an error pulse, and they change nothing.
- R3: A byte or word access is acknowledged in the 3rd cycle, counting the request cycle as the 1st. A longword access to the emulation register is acknowledged in the 6th cycle.
- R4: The acknowledge is high for exactly one cycle. Requests made while an access is pending are ignored: they neither change any register nor produce an acknowledge.
- R5: While the flash-enable mode input is low, reads of the three byte registers return 0. Writes to the control and erase-block registers are ignored.
- R6: Bit 7 of the control register follows the write-enable pin, so the register reads 0x80 after reset with the pin high and 0x00 with it low. Only bit 6 (software enable) is writable.
- R7: The status register always reads 0x00, and writes to it have no effect.
- R8: The erase-block register is forced to 0x00 whenever the pin is low or the software-enable bit is clear. Otherwise a byte write stores all 8 bits.
- R9: The emulation register resets to 0x0000. A word write at offset 8 loads bits 15:0 of the write data. A byte write at offset 8 loads the upper byte and a byte write at offset 9 loads the lower byte. Both modes are allowed.
- R10: A longword write at offset 8 loads bits 31:16 of the write data. If bits 15:0 are nonzero, the register is left unchanged and an error pulses. A longword read returns {register, 16'h0}.
- R11: An access to an unmapped offset, or any non-byte access at offset 9, completes in 3 cycles with read data 0, an error pulse and no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Byte offset in the bank |
| size | input | 2 | 0 byte, 1 word, 2 longword, 3 invalid |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with ack, 0 otherwise |
| ack | output | 1 | Completion pulse |
| err | output | 1 | Error pulse alongside ack |
| flash_en | input | 1 | Flash-enabled mode |
| wen_pin | input | 1 | External write-enable pin level |
| ctl1_q | output | 8 | Control register contents |
| eblk_q | output | 8 | Erase-block register contents |
| emu_q | output | 16 | Emulation register contents |

## Verification
Every offset from 0 to 15 is swept with every size code, both as a read and as a write. Each sweep runs under all four combinations of mode input and pin. This separates the size-legality rules, the per-register latencies and the gating by mode from one another. The write data patterns use distinct bytes per offset and size, so a write landing in the wrong byte lane shows up as a wrong value. Longword writes alternate between zero and nonzero lower halves, which separates a legal longword write from a rejected one. Finally, a request injected while an access is pending shows whether the pending-access lockout holds.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        T_NONE,
        T_CTL1,
        T_CTL2,
        T_EBLK,
        T_EMU_HI,
        T_EMU_LO,
        T_EMU_W,
        T_EMU_L
    } tgt_e;

    typedef struct packed {
        tgt_e tgt;
        logic bad;
        logic long_lat;
    } dec_t;

    typedef struct packed {
        logic        we;
        dec_t        dec;
        logic [31:0] wdata;
    } acc_t;

endpackage

// File: rtl/flash_ctl_decode.sv
module flash_ctl_decode
    import flash_ctl_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int CTL1_OFS = 0,
    parameter int CTL2_OFS = 1,
    parameter int EBLK_OFS = 2,
    parameter int EMU_OFS  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              we,
    input  logic [31:0]       wdata,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] A_CTL1  = ADDR_W'(CTL1_OFS);
    localparam logic [ADDR_W-1:0] A_CTL2  = ADDR_W'(CTL2_OFS);
    localparam logic [ADDR_W-1:0] A_EBLK  = ADDR_W'(EBLK_OFS);
    localparam logic [ADDR_W-1:0] A_EMU   = ADDR_W'(EMU_OFS);
    localparam logic [ADDR_W-1:0] A_EMU_1 = ADDR_W'(EMU_OFS + 1);

    size_e sz;
    assign sz = size_e'(size);

    always_comb begin
        dec = '{tgt: T_NONE, bad: 1'b1, long_lat: 1'b0};
        if (addr == A_CTL1 || addr == A_CTL2 || addr == A_EBLK) begin
            if (sz == SZ_BYTE) begin
                dec.bad = 1'b0;
                dec.tgt = (addr == A_CTL1) ? T_CTL1 :
                          (addr == A_CTL2) ? T_CTL2 : T_EBLK;
            end
        end else if (addr == A_EMU) begin
            unique case (sz)
                SZ_BYTE: dec = '{tgt: T_EMU_HI, bad: 1'b0, long_lat: 1'b0};
                SZ_WORD: dec = '{tgt: T_EMU_W,  bad: 1'b0, long_lat: 1'b0};
                SZ_LONG: dec = '{tgt: T_EMU_L,
                                 bad: we && (wdata[15:0] != 16'h0000),
                                 long_lat: 1'b1};
                default: dec = '{tgt: T_NONE,   bad: 1'b1, long_lat: 1'b0};
            endcase
        end else if (addr == A_EMU_1) begin
            if (sz == SZ_BYTE) begin
                dec = '{tgt: T_EMU_LO, bad: 1'b0, long_lat: 1'b0};
            end
        end
    end
endmodule

// File: rtl/flash_ctl_wait.sv
module flash_ctl_wait #(
    parameter int SHORT_LAT = 3,
    parameter int LONG_LAT  = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic long_lat,
    output logic busy,
    output logic fire
);
    localparam int CNT_W = (LONG_LAT > 4) ? $clog2(LONG_LAT) : 2;
    localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_LAT - 3);
    localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_LAT - 3);

    logic [CNT_W-1:0] cnt;

    assign fire = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cnt  <= long_lat ? LONG_LOAD : SHORT_LOAD;
            end
        end else if (cnt == '0) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/flash_ctl_store.sv
module flash_ctl_store
    import flash_ctl_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int EMU_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  acc_t             acc,
    input  logic             flash_en,
    input  logic             wen_pin,
    output logic [REG_W-1:0] ctl1_q,
    output logic [REG_W-1:0] eblk_q,
    output logic [EMU_W-1:0] emu_q,
    output logic [31:0]      rd_value
);
    localparam int HB = EMU_W / 2;

    logic swe;
    logic eblk_open;
    logic wr_ok;

    assign ctl1_q    = {wen_pin, swe, {(REG_W-2){1'b0}}};
    assign eblk_open = wen_pin && swe;
    assign wr_ok     = commit && acc.we && !acc.dec.bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            swe    <= 1'b0;
            eblk_q <= '0;
            emu_q  <= '0;
        end else begin
            if (wr_ok) begin
                unique case (acc.dec.tgt)
                    T_CTL1:   if (flash_en) swe <= acc.wdata[REG_W-2];
                    T_EBLK:   if (flash_en && eblk_open) eblk_q <= acc.wdata[REG_W-1:0];
                    T_EMU_HI: emu_q[EMU_W-1:HB] <= acc.wdata[HB-1:0];
                    T_EMU_LO: emu_q[HB-1:0]     <= acc.wdata[HB-1:0];
                    T_EMU_W:  emu_q <= acc.wdata[EMU_W-1:0];
                    T_EMU_L:  emu_q <= acc.wdata[31:32-EMU_W];
                    default: ;
                endcase
            end
            if (!eblk_open) begin
                eblk_q <= '0;
            end
        end
    end

    always_comb begin
        rd_value = '0;
        if (!acc.we && !acc.dec.bad) begin
            unique case (acc.dec.tgt)
                T_CTL1:   rd_value = flash_en ? 32'(ctl1_q) : '0;
                T_EBLK:   rd_value = flash_en ? 32'(eblk_q) : '0;
                T_EMU_HI: rd_value = 32'(emu_q[EMU_W-1:HB]);
                T_EMU_LO: rd_value = 32'(emu_q[HB-1:0]);
                T_EMU_W:  rd_value = 32'(emu_q);
                T_EMU_L:  rd_value = {emu_q, {(32-EMU_W){1'b0}}};
                default:  rd_value = '0;
            endcase
        end
    end
endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
    import flash_ctl_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int REG_W     = 8,
    parameter int EMU_W     = 16,
    parameter int EMU_OFS   = 8,
    parameter int SHORT_LAT = 3,
    parameter int LONG_LAT  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              ack,
    output logic              err,
    input  logic              flash_en,
    input  logic              wen_pin,
    output logic [REG_W-1:0]  ctl1_q,
    output logic [REG_W-1:0]  eblk_q,
    output logic [EMU_W-1:0]  emu_q
);
    dec_t        dec_now;
    acc_t        acc;
    logic        busy;
    logic        fire;
    logic        start;
    logic [31:0] rd_value;

    assign start = req && !busy;

    flash_ctl_decode #(
        .ADDR_W  (ADDR_W),
        .EMU_OFS (EMU_OFS)
    ) u_dec (
        .addr  (addr),
        .size  (size),
        .we    (we),
        .wdata (wdata),
        .dec   (dec_now)
    );

    flash_ctl_wait #(
        .SHORT_LAT (SHORT_LAT),
        .LONG_LAT  (LONG_LAT)
    ) u_wait (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .long_lat (dec_now.long_lat),
        .busy     (busy),
        .fire     (fire)
    );

    flash_ctl_store #(
        .REG_W (REG_W),
        .EMU_W (EMU_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .commit   (fire),
        .acc      (acc),
        .flash_en (flash_en),
        .wen_pin  (wen_pin),
        .ctl1_q   (ctl1_q),
        .eblk_q   (eblk_q),
        .emu_q    (emu_q),
        .rd_value (rd_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '{we: 1'b0, dec: '{tgt: T_NONE, bad: 1'b0, long_lat: 1'b0}, wdata: '0};
            ack   <= 1'b0;
            err   <= 1'b0;
            rdata <= '0;
        end else begin
            if (start) begin
                acc <= '{we: we, dec: dec_now, wdata: wdata};
            end
            ack   <= fire;
            err   <= fire && acc.dec.bad;
            rdata <= fire ? rd_value : '0;
        end
    end
endmodule

// File: rtl/flash_ctl_regs_chk.sv
module flash_ctl_regs_chk #(
    parameter int REG_W = 8,
    parameter int EMU_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             ack,
    input logic             err,
    input logic [31:0]      rdata,
    input logic             wen_pin,
    input logic [REG_W-1:0] ctl1_q,
    input logic [REG_W-1:0] eblk_q,
    input logic [EMU_W-1:0] emu_q
);
    assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    assert_err_with_ack_R2: assert property (@(posedge clk) disable iff (rst)
        err |-> ack);

    assert_err_zero_data_R11: assert property (@(posedge clk) disable iff (rst)
        err |-> (rdata == 32'h0));

    assert_eblk_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (!wen_pin || !ctl1_q[REG_W-2]) |=> (eblk_q == '0));

    assert_emu_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !ack |-> $stable(emu_q));

    assert_emu_reject_R10: assert property (@(posedge clk) disable iff (rst)
        err |-> $stable(emu_q));
endmodule

bind flash_ctl_regs flash_ctl_regs_chk #(.REG_W(REG_W), .EMU_W(EMU_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ack     (ack),
    .err     (err),
    .rdata   (rdata),
    .wen_pin (wen_pin),
    .ctl1_q  (ctl1_q),
    .eblk_q  (eblk_q),
    .emu_q   (emu_q)
);

// File: tb/flash_ctl_regs_test.sv
module flash_ctl_regs_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [1:0]  size = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack;
    logic        err;
    logic        flash_en = 1'b1;
    logic        wen_pin = 1'b1;
    logic [7:0]  ctl1_q;
    logic [7:0]  eblk_q;
    logic [15:0] emu_q;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    logic        m_swe;
    logic [7:0]  m_eblk;
    logic [15:0] m_emu;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_ctl_regs uut (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .size(size),
        .wdata(wdata), .rdata(rdata), .ack(ack), .err(err),
        .flash_en(flash_en), .wen_pin(wen_pin),
        .ctl1_q(ctl1_q), .eblk_q(eblk_q), .emu_q(emu_q)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL R4 watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic model(input logic w, input logic [3:0] a, input logic [1:0] s,
                         input logic [31:0] d, output logic [31:0] rd,
                         output logic e, output int lat);
        lat = (a == 4'd8 && s == 2'd2) ? 6 : 3;
        e = 1'b0;
        rd = '0;
        if (a <= 4'd2) begin
            if (s != 2'd0) e = 1'b1;
            else if (!w) begin
                if (flash_en && a == 4'd0) rd = {24'h0, wen_pin, m_swe, 6'h0};
                if (flash_en && a == 4'd2) rd = {24'h0, m_eblk};
            end else if (flash_en) begin
                if (a == 4'd0) m_swe = d[6];
                if (a == 4'd2 && wen_pin && m_swe) m_eblk = d[7:0];
            end
        end else if (a == 4'd8) begin
            case (s)
                2'd0: if (w) m_emu[15:8] = d[7:0]; else rd = {24'h0, m_emu[15:8]};
                2'd1: if (w) m_emu = d[15:0]; else rd = {16'h0, m_emu};
                2'd2: if (w) begin
                          if (d[15:0] != 16'h0) e = 1'b1; else m_emu = d[31:16];
                      end else rd = {m_emu, 16'h0};
                default: e = 1'b1;
            endcase
        end else if (a == 4'd9 && s == 2'd0) begin
            if (w) m_emu[7:0] = d[7:0]; else rd = {24'h0, m_emu[7:0]};
        end else begin
            e = 1'b1;
        end
        if (!(wen_pin && m_swe)) m_eblk = 8'h0;
    endtask

    task automatic check_ports(input string tag);
        check(ctl1_q == {wen_pin, m_swe, 6'h0}, {tag, " R6 ctl1_q"}, 32'(ctl1_q), 32'({wen_pin, m_swe, 6'h0}));
        check(eblk_q == m_eblk, {tag, " R8 eblk_q"}, 32'(eblk_q), 32'(m_eblk));
        check(emu_q == m_emu, {tag, " R9 emu_q"}, 32'(emu_q), 32'(m_emu));
    endtask

    task automatic xfer(input logic w, input logic [3:0] a, input logic [1:0] s,
                        input logic [31:0] d, input string tag);
        logic [31:0] er;
        logic ee;
        int el;
        int n;
        model(w, a, s, d, er, ee, el);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; size = s; wdata = d;
        @(negedge clk);
        req = 1'b0;
        n = 1;
        while (!ack && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(n == el - 1, {tag, " R3 latency"}, 32'(n + 1), 32'(el));
        check(rdata == er, {tag, " R1 rdata"}, rdata, er);
        check(err == ee, {tag, " R2 err"}, 32'(err), 32'(ee));
        @(negedge clk);
        check(!ack, {tag, " R4 ack pulse"}, 32'(ack), 32'h0);
        check_ports(tag);
    endtask

    task automatic do_reset(input logic pin);
        wen_pin = pin;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_swe = 1'b0; m_eblk = 8'h0; m_emu = 16'h0;
        @(negedge clk);
    endtask

    initial begin
        m_swe = 1'b0; m_eblk = 8'h0; m_emu = 16'h0;

        do_reset(1'b1);
        check(ctl1_q == 8'h80, "R6 reset ctl1 pin high", 32'(ctl1_q), 32'h80);
        check(emu_q == 16'h0, "R9 reset emu", 32'(emu_q), 32'h0);
        check(eblk_q == 8'h0, "R8 reset eblk", 32'(eblk_q), 32'h0);
        check(!ack && !err, "R4 reset ack/err", 32'({ack, err}), 32'h0);
        xfer(1'b0, 4'd1, 2'd0, 32'h0, "R7 status read");
        xfer(1'b1, 4'd1, 2'd0, 32'hFF, "R7 status write");
        xfer(1'b0, 4'd1, 2'd0, 32'h0, "R7 status reread");

        do_reset(1'b0);
        check(ctl1_q == 8'h00, "R6 reset ctl1 pin low", 32'(ctl1_q), 32'h00);

        for (int p = 0; p < 2; p++) begin
            for (int f = 0; f < 2; f++) begin
                wen_pin = p[0];
                flash_en = f[0];
                if (!(wen_pin && m_swe)) m_eblk = 8'h0;
                @(negedge clk);
                xfer(1'b1, 4'd0, 2'd0, 32'hFF, "R6 set swe");
                xfer(1'b1, 4'd2, 2'd0, 32'h5A + 32'(p * 2 + f), "R8 eblk write");
                for (int a = 0; a < 16; a++) begin
                    for (int s = 0; s < 4; s++) begin
                        xfer(1'b0, 4'(a), 2'(s), 32'h0, "R5 read sweep");
                    end
                end
                for (int a = 0; a < 16; a++) begin
                    for (int s = 0; s < 4; s++) begin
                        xfer(1'b1, 4'(a), 2'(s),
                             {8'(a * 16 + s), 8'(8'hC3 ^ 8'(a)), 16'h0000}, "R10 write sweep zero low");
                        xfer(1'b1, 4'(a), 2'(s),
                             {8'(8'h3C ^ 8'(s)), 8'(a), 8'(p * 4 + f), 8'(8'h40 | 8'(a * 4 + s))},
                             "R11 write sweep nonzero low");
                        xfer(1'b0, 4'(a), 2'(s), 32'h0, "R9 readback");
                    end
                end
                xfer(1'b1, 4'd0, 2'd0, 32'h40, "R6 swe again");
                xfer(1'b1, 4'd2, 2'd0, 32'hA5, "R8 eblk again");
                xfer(1'b1, 4'd0, 2'd0, 32'h00, "R8 swe clear");
                xfer(1'b0, 4'd2, 2'd0, 32'h0, "R8 eblk after clear");
            end
        end

        flash_en = 1'b1;
        wen_pin = 1'b1;
        @(negedge clk);
        xfer(1'b1, 4'd8, 2'd1, 32'h0000_1111, "R9 emu word base");
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 4'd8; size = 2'd2; wdata = 32'h7777_0000;
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 4'd8; size = 2'd1; wdata = 32'h0000_2222;
        @(negedge clk);
        req = 1'b0;
        begin
            int n;
            int acks;
            n = 2;
            acks = 0;
            while (!ack && n < 20) begin
                @(negedge clk);
                n++;
            end
            check(n == 5, "R3 long latency with injected req", 32'(n + 1), 32'd6);
            check(emu_q == 16'h7777, "R4 pending request ignored", 32'(emu_q), 32'h7777);
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (ack) acks++;
            end
            check(acks == 0, "R4 no extra ack", 32'(acks), 32'h0);
            check(emu_q == 16'h7777, "R4 emu after idle", 32'(emu_q), 32'h7777);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule